// File: doc/BRIEF.md
# SPI Flash Command Engine with Shared Ring Buffer

This block is a register-driven SPI master that carries out one flash-style transaction each time the host starts it. The host loads three things: an opcode, a packed byte count, and up to eight payload bytes. It pushes the payload through a byte-wide data port into an eight-slot ring buffer. The engine then takes chip select low and shifts out the opcode, then the payload. It keeps clocking for the requested number of response bytes.

Transmit and receive share the one ring buffer, and the buffer is never cleared. The byte clocked in during every byte after the opcode is stored in that buffer, so the response bytes follow directly behind the slots used by the payload. When the engine finishes, the host rewinds the single host-visible pointer and reads the results back through the same data port.

Top module: `spi_cmd_engine`

## Requirements
- R1: Offset 0x0 holds the opcode byte, which is read back unchanged. The opcode is always the first byte shifted out, most significant bit first. It is never stored in the ring buffer.
- R2: Offset 0x1 holds the receive count in bits 7:4 and the transmit payload count (opcode excluded) in bits 3:0. A written field above 8 is stored as 8.
- R3: Writing 1 to bit 0 of offset 0x2 starts a transaction. That bit reads 1 while the transaction runs and reads 0 once it is done. Writing 1 to bit 4 of offset 0x2 sets the pointer to 0. The other bits of 0x2 read 0.
- R4: A write or a read at offset 0xC accesses the slot at the pointer, then advances the pointer by one modulo 8. Offset 0xD returns the pointer in bits 2:0 with zeros above. Unmapped offsets read 0.
- R5: The ring buffer is never cleared. A slot that no host write and no received byte touches keeps its contents.
- R6: A transaction shifts out, in order: the opcode, then payload slots 0 to tx-1, then 0xFF for each receive byte.
- R7: The byte received during transaction byte k (k counted from 1 after the opcode) is stored in slot (k-1) mod 8. Responses therefore start at slot tx, and on wrap the later byte wins. The engine does not move the host pointer.
- R8: With tx and rx counts, chip select stays low for exactly 16*HALF_DIV*(1+tx+rx) clock cycles. Exactly 8*(1+tx+rx) rising SCK edges occur in that time. This holds when tx is 0: every requested receive byte is captured and none is dropped.
- R9: The SPI mode is mode 0. SCK idles low. Chip select falls HALF_DIV cycles before the first rising edge. MOSI changes only while SCK is low. MISO is sampled on the rising edge.
- R10: While a transaction runs, writes to offsets 0x0, 0x1, 0x2 and 0xC are ignored, including a second start and a pointer reset. Reads at 0xC do not advance the pointer during that time.
- R11: After reset, chip select is high, SCK is low, the pointer and busy bit are 0, and the opcode, the counts and all slots are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe, one cycle (advances pointer at 0xC) |
| reg_rdata | output | 8 | Read data for the addressed offset |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench builds the engine with HALF_DIV set to 3, so each half period of SCK lasts three system cycles. An odd division exposes any off-by-one error in the half-period timer. It also lets the timing checks tell apart the chip-select setup time, the total chip-select low time and a count of rising edges. Transactions with counts of 3/2, 0/8, 8/8 and 1/0 cover these cases:
- the receive-only case;
- the full wrap, where late responses overwrite early ones;
- stale slots that survive a short transaction.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  output logic       spi_cs_n,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso
);

  localparam int SLOTS = 8;
  localparam int TW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [3:0] A_OP   = 4'h0;
  localparam logic [3:0] A_CNT  = 4'h1;
  localparam logic [3:0] A_CTL  = 4'h2;
  localparam logic [3:0] A_DATA = 4'hC;
  localparam logic [3:0] A_PTR  = 4'hD;

  logic [7:0]    opcode_q;
  logic [3:0]    txn_q, rxn_q;
  logic [7:0]    ring_q [SLOTS];
  logic [2:0]    ptr_q;
  logic          busy_q, cs_n_q, sck_q;
  logic [TW-1:0] tmr_q;
  logic [2:0]    bit_q;
  logic [4:0]    byte_q;
  logic [7:0]    sh_tx_q, sh_rx_q;

  function automatic logic [3:0] sat8(input logic [3:0] v);
    return (v > 4'd8) ? 4'd8 : v;
  endfunction

  wire       acc_wr    = reg_wr & ~busy_q;
  wire       acc_rd    = reg_rd & ~busy_q;
  wire       start     = acc_wr && (reg_addr == A_CTL) && reg_wdata[0];
  wire       tick      = (tmr_q == TW'(HALF_DIV - 1));
  wire [4:0] last_byte = 5'(txn_q) + 5'(rxn_q);
  wire [4:0] nxt_byte  = byte_q + 5'd1;
  wire [7:0] rx_byte   = {sh_rx_q[6:0], spi_miso};
  wire [7:0] tx_next   = (nxt_byte <= 5'(txn_q)) ? ring_q[byte_q[2:0]] : 8'hFF;
  wire [2:0] cap_slot  = 3'(byte_q - 5'd1);
  wire       capture   = busy_q && tick && !sck_q && (bit_q == 3'd7) && (byte_q != 5'd0);

  assign spi_cs_n = cs_n_q;
  assign spi_sck  = sck_q;
  assign spi_mosi = sh_tx_q[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opcode_q <= '0;
      txn_q    <= '0;
      rxn_q    <= '0;
      ptr_q    <= '0;
    end else if (acc_wr) begin
      case (reg_addr)
        A_OP:   opcode_q <= reg_wdata;
        A_CNT:  begin
          rxn_q <= sat8(reg_wdata[7:4]);
          txn_q <= sat8(reg_wdata[3:0]);
        end
        A_CTL:  if (reg_wdata[4]) ptr_q <= '0;
        A_DATA: ptr_q <= ptr_q + 3'd1;
        default: ;
      endcase
    end else if (acc_rd && reg_addr == A_DATA) begin
      ptr_q <= ptr_q + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) ring_q[i] <= '0;
    end else if (capture) begin
      ring_q[cap_slot] <= rx_byte;
    end else if (acc_wr && reg_addr == A_DATA) begin
      ring_q[ptr_q] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      sck_q   <= 1'b0;
      tmr_q   <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      sh_tx_q <= '0;
      sh_rx_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q  <= 1'b1;
        cs_n_q  <= 1'b0;
        sck_q   <= 1'b0;
        tmr_q   <= '0;
        bit_q   <= '0;
        byte_q  <= '0;
        sh_tx_q <= opcode_q;
      end
    end else if (!tick) begin
      tmr_q <= tmr_q + TW'(1);
    end else begin
      tmr_q <= '0;
      if (!sck_q) begin
        sck_q   <= 1'b1;
        sh_rx_q <= rx_byte;
      end else begin
        sck_q <= 1'b0;
        if (bit_q == 3'd7) begin
          if (byte_q == last_byte) begin
            busy_q <= 1'b0;
            cs_n_q <= 1'b1;
          end else begin
            byte_q  <= nxt_byte;
            bit_q   <= '0;
            sh_tx_q <= tx_next;
          end
        end else begin
          bit_q   <= bit_q + 3'd1;
          sh_tx_q <= {sh_tx_q[6:0], 1'b0};
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_OP:    reg_rdata = opcode_q;
      A_CNT:   reg_rdata = {rxn_q, txn_q};
      A_CTL:   reg_rdata = {7'd0, busy_q};
      A_DATA:  reg_rdata = ring_q[ptr_q];
      A_PTR:   reg_rdata = {5'd0, ptr_q};
      default: reg_rdata = 8'h00;
    endcase
  end

  a_r9_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  a_r9_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));

  a_r8_cs_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> $fell(spi_sck));

  a_r10_opcode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(opcode_q));

  a_r7_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(ptr_q));

  a_r2_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_q <= 4'd8) && (rxn_q <= 4'd8));

endmodule

// File: tb/spi_cmd_engine_tb_top.sv
module spi_cmd_engine_tb_top;
  localparam int HALF = 3;
  localparam int TCLK = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       spi_cs_n, spi_sck, spi_mosi;
  logic       spi_miso = 1'b0;

  always #(TCLK/2) clk = ~clk;

  spi_cmd_engine #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_mosi_q [$];
  logic [7:0] model_ring [8];
  logic [2:0] model_ptr;
  int txn_id = 0;

  function automatic logic [7:0] resp(input int t, input int j);
    return 8'((8'h5A ^ (j * 37)) + t * 13);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model and scoreboard monitor
  int s_bit, s_byte, rise_cnt;
  logic [7:0] s_out, s_in;
  realtime t_cs_fall, t_first_rise, t_cs_rise;

  always @(negedge spi_cs_n) if (rst_n) begin
    s_bit = 0; s_byte = 0; rise_cnt = 0;
    s_out = resp(txn_id, 0);
    t_cs_fall = $realtime;
    spi_miso <= s_out[7];
  end

  always @(posedge spi_cs_n) if (rst_n) t_cs_rise = $realtime;

  always @(posedge spi_sck) if (!spi_cs_n) begin
    if (rise_cnt == 0) t_first_rise = $realtime;
    rise_cnt++;
    s_in = {s_in[6:0], spi_mosi};
    if (s_bit == 7) begin
      if (exp_mosi_q.size() == 0) chk("R6 unexpected mosi byte", s_in, 8'hxx);
      else chk("R6 R1 mosi byte", s_in, exp_mosi_q.pop_front());
      s_bit = 0; s_byte++;
      s_out = resp(txn_id, s_byte);
    end else s_bit++;
  end

  always @(negedge spi_sck) if (!spi_cs_n) spi_miso <= s_out[7 - s_bit];

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    do rd(4'h2, v); while (v[0]);
  endtask

  task automatic check_ring(input string req);
    logic [7:0] v;
    wr(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) begin
      rd(4'hC, v);
      chk(req, v, model_ring[i]);
    end
    rd(4'hD, v);
    chk("R4 pointer wraps to 0 after 8 reads", v, 8'h00);
    model_ptr = 3'd0;
  endtask

  task automatic run_txn(input logic [7:0] op, input int tx, input int rx, input bit poke_busy);
    logic [7:0] v;
    int n;
    n = 1 + tx + rx;
    wr(4'h0, op);
    wr(4'h1, {4'(rx), 4'(tx)});
    wr(4'h2, 8'h10);
    for (int i = 0; i < tx; i++) begin
      wr(4'hC, 8'(8'h20 + i * 9 + txn_id));
      model_ring[i] = 8'(8'h20 + i * 9 + txn_id);
    end
    model_ptr = 3'(tx);
    txn_id++;
    exp_mosi_q.push_back(op);
    for (int i = 0; i < tx; i++) exp_mosi_q.push_back(model_ring[i]);
    for (int i = 0; i < rx; i++) exp_mosi_q.push_back(8'hFF);
    wr(4'h2, 8'h01);
    rd(4'h2, v);
    chk("R3 busy reads 1 while running", v, 8'h01);
    if (poke_busy) begin
      wr(4'h0, 8'h55);
      wr(4'h1, 8'h11);
      wr(4'hC, 8'h77);
      wr(4'h2, 8'h11);
      rd(4'hC, v);
    end
    wait_idle();
    for (int k = 1; k < n; k++) model_ring[(k - 1) % 8] = resp(txn_id, k);
    chk("R9 cs setup half period", int'((t_first_rise - t_cs_fall) / TCLK), HALF);
    chk("R8 cs low duration", int'((t_cs_rise - t_cs_fall) / TCLK), 16 * HALF * n);
    chk("R8 rising edge count", rise_cnt, 8 * n);
    chk("R6 all expected bytes seen", exp_mosi_q.size(), 0);
    rd(4'h2, v);
    chk("R3 busy clears", v, 8'h00);
    rd(4'h0, v);
    chk("R10 R1 opcode unchanged", v, op);
    rd(4'h1, v);
    chk("R10 R2 counts unchanged", v, {4'(rx), 4'(tx)});
    rd(4'hD, v);
    chk("R7 R10 pointer untouched by engine", v, {5'd0, model_ptr});
    check_ring("R7 R5 ring contents");
  endtask

  bit finished = 1'b0;

  initial begin
    #(TCLK * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 8; i++) model_ring[i] = 8'h00;
    model_ptr = 3'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 cs_n high", spi_cs_n, 1'b1);
    chk("R11 sck low", spi_sck, 1'b0);
    rd(4'h2, v); chk("R11 busy 0", v, 8'h00);
    rd(4'hD, v); chk("R11 pointer 0", v, 8'h00);
    rd(4'h0, v); chk("R11 opcode 0", v, 8'h00);
    rd(4'h5, v); chk("R4 unmapped reads 0", v, 8'h00);

    wr(4'h1, 8'hF9); rd(4'h1, v); chk("R2 saturate both", v, 8'h88);
    wr(4'h1, 8'h93); rd(4'h1, v); chk("R2 saturate rx only", v, 8'h83);

    wr(4'h2, 8'h10);
    for (int i = 0; i < 9; i++) begin
      wr(4'hC, 8'(8'hC0 + i));
      model_ring[i % 8] = 8'(8'hC0 + i);
    end
    rd(4'hD, v); chk("R4 pointer wraps modulo 8", v, 8'h01);
    wr(4'h2, 8'h10); rd(4'hD, v); chk("R3 pointer reset", v, 8'h00);
    check_ring("R4 R11 host ring writes");

    run_txn(8'h9F, 3, 2, 1'b1);
    run_txn(8'h0B, 0, 8, 1'b0);
    run_txn(8'hA5, 8, 8, 1'b0);
    run_txn(8'h06, 1, 0, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule